// File: doc/BRIEF.md
# DMA Address and Count Engine

This block sequences byte transfers between a byte-wide peripheral bus port and a memory port, for use inside a SCSI bus controller. Software loads three registers (a transfer address, a transfer count and a direction code) and then issues a start pulse. After a fixed start latency the engine moves one byte per accepted handshake. For each byte it makes one memory access at the current address, then advances the address and moves the count one step toward zero.

The count register holds the length as a negative number in two's complement and counts upward. A count of zero at start stands for a whole buffer of 2^14 bytes. When the final byte is moved, the engine raises a sticky end-of-transfer flag and a sticky interrupt request, and it emits a single one-cycle completion pulse. For an outbound transfer there is one special case. If the bus has moved into the status phase and a byte leaves exactly two bytes outstanding, the engine shortens the transfer by one byte.

Top module: `dma_xfer_engine`

## Requirements
- R1: A full write with `regSel`=0 loads all 14 bits of `regWrData` into the address. `addrQ` shows the new value on the cycle after the write edge.
- R2: Byte-mode address writes (`regByteWr`=1, `regSel`=0) come in pairs. After reset, the first write of a pair sets address bits 13:8 from `regWrData[5:0]` and clears bits 7:0. The second write ORs `regWrData[7:0]` into bits 7:0. The next byte write then starts a new pair.
- R3: With `regSel`=1, a write loads the count. With `regSel`=2, a write loads the direction from `regWrData[7:0]`. `countQ` and `dirQ` always show the current values. Any register write made while `busy` is high has no effect.
- R4: The number of bytes moved equals the 14-bit two's-complement negation of the count. Each byte adds one to the count and one to the address, both wrapping at 14 bits. The count reads zero when the transfer completes.
- R5: A count of zero at start moves 16384 bytes.
- R6: Direction code 1 means inbound. In that case `busInReady` is high, and each accepted `busInValid` writes `busInData` to `memAddr` with `memWe`. Any other code means outbound. In that case `busOutValid` is high, and `busOutData` carries the memory byte read at `memAddr`.
- R7: An outbound byte may complete while `busStatusPhase` is high and leave exactly two bytes outstanding. In that case the count advances by two and only one more byte is moved.
- R8: When the final byte completes, `dmaEnd` and `intReq` set on that edge and `donePulse` is high for exactly one cycle. Both flags clear when the next start is accepted.
- R9: A start is accepted at a clock edge E0 while the engine is idle. `busy` rises at E0, and no handshake strobe appears before the cycle that follows edge E0+START_DELAY.
- R10: While the bus side withholds its handshake, the count and the address hold their values and no completion is signalled.
- R11: A start pulse that arrives while `busy` is high is ignored, and the timing of the transfer already in flight does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regByteWr | input | 1 | Byte-mode write (address register only) |
| regSel | input | 2 | 0 address, 1 count, 2 direction |
| regWrData | input | 14 | Register write data |
| addrQ | output | 14 | Current address |
| countQ | output | 14 | Current count (negative length) |
| dirQ | output | 8 | Direction code |
| startReq | input | 1 | Start pulse |
| busStatusPhase | input | 1 | Bus is in the status phase |
| busInValid | input | 1 | Inbound byte offered |
| busInData | input | 8 | Inbound byte |
| busInReady | output | 1 | Engine accepts inbound bytes |
| busOutValid | output | 1 | Outbound byte offered |
| busOutData | output | 8 | Outbound byte |
| busOutReady | input | 1 | Bus accepts outbound byte |
| memAddr | output | 14 | Memory byte address |
| memWe | output | 1 | Memory write enable |
| memWrData | output | 8 | Memory write data |
| memRdData | input | 8 | Memory read data (combinational) |
| busy | output | 1 | Transfer pending or running |
| dmaEnd | output | 1 | Sticky end-of-transfer flag |
| intReq | output | 1 | Sticky interrupt request |
| donePulse | output | 1 | One-cycle completion pulse |

## Verification
A register write shows on the outputs one cycle after its write edge. The bench therefore reads the value back at the next falling edge. Handshake strobes are due exactly START_DELAY edges after the start edge, so the bench checks START_DELAY quiet cycles and then expects the strobe. In each transfer cycle the memory and bus outputs follow the current address combinationally, so they are sampled one time unit after the inputs are driven in the low half of the clock. The count, address and completion flags are sampled at the falling edge after the handshake edge.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_DIR   = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } engStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic wrAllow;  // register writes permitted
    logic loadLen;  // capture remaining length at start
    logic step;     // one byte moved this cycle
    logic bump;     // status-phase shortening on this byte
  } dpStrobeT;

endpackage

// File: rtl/dma_eng_datapath.sv
module dma_eng_datapath
  import dma_eng_pkg::*;
#(
  parameter int XFER_W = 14,
  parameter int DIR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regByteWr,
  input  logic [1:0]        regSel,
  input  logic [XFER_W-1:0] regWrData,
  input  dpStrobeT          ctl,
  output logic [XFER_W-1:0] addrQ,
  output logic [XFER_W-1:0] countQ,
  output logic [DIR_W-1:0]  dirQ,
  output logic [XFER_W:0]   leftQ
);

  localparam int HI_W = XFER_W - 8;
  localparam logic [XFER_W:0] FULL_LEN = (XFER_W+1)'(1) << XFER_W;

  logic              hiNext;
  logic [XFER_W-1:0] negLen;
  logic [XFER_W:0]   startLen;
  logic [XFER_W-1:0] cntInc;
  logic [XFER_W:0]   leftDec;

  always_comb begin
    negLen   = (~countQ) + 1'b1;
    startLen = (countQ == '0) ? FULL_LEN : {1'b0, negLen};
    cntInc   = ctl.bump ? XFER_W'(2) : XFER_W'(1);
    leftDec  = ctl.bump ? (XFER_W+1)'(2) : (XFER_W+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      countQ <= '0;
      dirQ   <= '0;
      leftQ  <= '0;
      hiNext <= 1'b1;
    end else begin
      if (ctl.wrAllow && regWrEn) begin
        case (regSel)
          SEL_ADDR: begin
            if (regByteWr) begin
              if (hiNext) begin
                addrQ  <= {regWrData[HI_W-1:0], 8'h00};
                hiNext <= 1'b0;
              end else begin
                addrQ  <= addrQ | {{HI_W{1'b0}}, regWrData[7:0]};
                hiNext <= 1'b1;
              end
            end else begin
              addrQ <= regWrData;
            end
          end
          SEL_COUNT: countQ <= regWrData;
          SEL_DIR:   dirQ   <= regWrData[DIR_W-1:0];
          default: ;
        endcase
      end
      if (ctl.loadLen) leftQ <= startLen;
      if (ctl.step) begin
        addrQ  <= addrQ + 1'b1;
        countQ <= countQ + cntInc;
        leftQ  <= leftQ - leftDec;
      end
    end
  end

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.bump) |=> countQ == XFER_W'($past(countQ) + 1'b1));

  assert_count_bump_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && ctl.bump) |=> countQ == XFER_W'($past(countQ) + 2'd2));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> addrQ == XFER_W'($past(addrQ) + 1'b1));

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.step && !(ctl.wrAllow && regWrEn)) |=> ($stable(countQ) && $stable(addrQ)));

endmodule

// File: rtl/dma_eng_ctrl.sv
module dma_eng_ctrl
  import dma_eng_pkg::*;
#(
  parameter int XFER_W      = 14,
  parameter int DIR_W       = 8,
  parameter int START_DELAY = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [DIR_W-1:0] dirQ,
  input  logic [XFER_W:0]  leftQ,
  input  logic             busStatusPhase,
  input  logic             busInValid,
  input  logic             busOutReady,
  output dpStrobeT         ctl,
  output logic             busy,
  output logic             busInReady,
  output logic             busOutValid,
  output logic             memWe,
  output logic             dmaEnd,
  output logic             intReq,
  output logic             donePulse
);

  localparam int DLY_W    = (START_DELAY > 1) ? $clog2(START_DELAY) : 1;
  localparam int DLY_INIT = (START_DELAY > 0) ? START_DELAY - 1 : 0;

  engStateT         state;
  logic [DLY_W-1:0] dly;
  logic             dirIn;
  logic             xferOn;
  logic             fire;
  logic             lastByte;

  always_comb begin
    dirIn       = (dirQ == DIR_W'(1));
    xferOn      = (state == ST_XFER);
    fire        = xferOn && (dirIn ? busInValid : busOutReady);
    lastByte    = (leftQ == (XFER_W+1)'(1));
    busy        = (state != ST_IDLE);
    busInReady  = xferOn && dirIn;
    busOutValid = xferOn && !dirIn;
    memWe       = fire && dirIn;
    ctl.wrAllow = (state == ST_IDLE);
    ctl.loadLen = (state == ST_IDLE) && startReq;
    ctl.step    = fire;
    ctl.bump    = fire && !dirIn && busStatusPhase && (leftQ == (XFER_W+1)'(3));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      dly       <= '0;
      dmaEnd    <= 1'b0;
      intReq    <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= fire && lastByte;
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            dmaEnd <= 1'b0;
            intReq <= 1'b0;
            if (START_DELAY == 0) begin
              state <= ST_XFER;
            end else begin
              state <= ST_WAIT;
              dly   <= DLY_W'(DLY_INIT);
            end
          end
        end
        ST_WAIT: begin
          if (dly == '0) state <= ST_XFER;
          else           dly   <= dly - 1'b1;
        end
        ST_XFER: begin
          if (fire && lastByte) begin
            state  <= ST_IDLE;
            dmaEnd <= 1'b1;
            intReq <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  assert_done_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (dmaEnd && intReq && !busy));

  assert_start_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((START_DELAY > 0) && $rose(busy)) |-> (!busInReady && !busOutValid));

  assert_stall_no_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    (xferOn && !fire) |=> (!donePulse && busy));

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
#(
  parameter int XFER_W      = 14,
  parameter int DIR_W       = 8,
  parameter int START_DELAY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regByteWr,
  input  logic [1:0]        regSel,
  input  logic [XFER_W-1:0] regWrData,
  output logic [XFER_W-1:0] addrQ,
  output logic [XFER_W-1:0] countQ,
  output logic [DIR_W-1:0]  dirQ,
  input  logic              startReq,
  input  logic              busStatusPhase,
  input  logic              busInValid,
  input  logic [7:0]        busInData,
  output logic              busInReady,
  output logic              busOutValid,
  output logic [7:0]        busOutData,
  input  logic              busOutReady,
  output logic [XFER_W-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData,
  output logic              busy,
  output logic              dmaEnd,
  output logic              intReq,
  output logic              donePulse
);

  dpStrobeT        ctl;
  logic [XFER_W:0] leftQ;

  dma_eng_datapath #(.XFER_W(XFER_W), .DIR_W(DIR_W)) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regByteWr (regByteWr),
    .regSel    (regSel),
    .regWrData (regWrData),
    .ctl       (ctl),
    .addrQ     (addrQ),
    .countQ    (countQ),
    .dirQ      (dirQ),
    .leftQ     (leftQ)
  );

  dma_eng_ctrl #(.XFER_W(XFER_W), .DIR_W(DIR_W), .START_DELAY(START_DELAY)) uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .startReq       (startReq),
    .dirQ           (dirQ),
    .leftQ          (leftQ),
    .busStatusPhase (busStatusPhase),
    .busInValid     (busInValid),
    .busOutReady    (busOutReady),
    .ctl            (ctl),
    .busy           (busy),
    .busInReady     (busInReady),
    .busOutValid    (busOutValid),
    .memWe          (memWe),
    .dmaEnd         (dmaEnd),
    .intReq         (intReq),
    .donePulse      (donePulse)
  );

  assign memAddr    = addrQ;
  assign memWrData  = busInData;
  assign busOutData = memRdData;

endmodule

// File: tb/tb_dma_xfer_engine.sv
`timescale 1ns/1ps
module tb_dma_xfer_engine;

  localparam int XFER_W = 14;
  localparam int DIR_W  = 8;
  localparam int DELAY  = 3;
  localparam int FULL   = 1 << XFER_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regByteWr = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [XFER_W-1:0] regWrData = '0;
  logic [XFER_W-1:0] addrQ, countQ, memAddr;
  logic [DIR_W-1:0] dirQ;
  logic startReq = 1'b0, busStatusPhase = 1'b0;
  logic busInValid = 1'b0, busOutReady = 1'b0;
  logic [7:0] busInData = 8'h00;
  logic busInReady, busOutValid, memWe, busy, dmaEnd, intReq, donePulse;
  logic [7:0] busOutData, memWrData, memRdData;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign memRdData = memAddr[7:0] ^ 8'hA5;

  dma_xfer_engine #(.XFER_W(XFER_W), .DIR_W(DIR_W), .START_DELAY(DELAY)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regByteWr(regByteWr),
    .regSel(regSel), .regWrData(regWrData), .addrQ(addrQ), .countQ(countQ),
    .dirQ(dirQ), .startReq(startReq), .busStatusPhase(busStatusPhase),
    .busInValid(busInValid), .busInData(busInData), .busInReady(busInReady),
    .busOutValid(busOutValid), .busOutData(busOutData), .busOutReady(busOutReady),
    .memAddr(memAddr), .memWe(memWe), .memWrData(memWrData), .memRdData(memRdData),
    .busy(busy), .dmaEnd(dmaEnd), .intReq(intReq), .donePulse(donePulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input int data, input bit byteMode);
    regWrEn   = 1'b1;
    regSel    = sel;
    regWrData = XFER_W'(data);
    regByteWr = byteMode;
    @(posedge clk);
    @(negedge clk);
    regWrEn   = 1'b0;
    regByteWr = 1'b0;
  endtask

  task automatic pulseStart();
    startReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // nominal: programmed length; dirVal: direction code; stsPh: status phase
  task automatic runBurst(input int nominal, input int dirVal, input int a0,
                          input bit stsPh, input int stallEvery);
    bit dirIn = (dirVal == 1);
    int cntInit = (FULL - nominal) % FULL;
    int expAddr = a0;
    int expCnt = cntInit;
    int left = nominal;
    int cyc = 0;
    writeReg(2'd0, a0, 1'b0);
    writeReg(2'd1, cntInit, 1'b0);
    writeReg(2'd2, dirVal, 1'b0);
    chk(int'(countQ) == cntInit, "R3", "count readback", int'(countQ), cntInit);
    busStatusPhase = stsPh;
    pulseStart();
    chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
    chk(dmaEnd == 1'b0 && intReq == 1'b0, "R8", "flags cleared by start", int'(dmaEnd), 0);
    for (int k = 0; k < DELAY; k++) begin
      chk(!busInReady && !busOutValid, "R9", "strobe during start latency",
          int'(busInReady | busOutValid), 0);
      @(posedge clk);
      @(negedge clk);
    end
    while (left > 0 && cyc < 40000) begin
      bit stall = (stallEvery > 0) && ((cyc % stallEvery) == stallEvery - 1);
      busInData   = 8'(expAddr * 7 + 3);
      busInValid  = dirIn && !stall;
      busOutReady = !dirIn && !stall;
      #1;
      chk(dirIn ? busInReady : busOutValid, "R6", "direction strobe", 0, 1);
      chk(int'(memAddr) == expAddr, "R4", "memory address", int'(memAddr), expAddr);
      chk(int'(countQ) == expCnt, "R10", "count value/hold", int'(countQ), expCnt);
      chk(donePulse == 1'b0, "R10", "no early done", int'(donePulse), 0);
      if (dirIn) begin
        chk(memWe == !stall, "R6", "memory write enable", int'(memWe), int'(!stall));
        chk(memWrData == busInData, "R6", "memory write data", int'(memWrData), int'(busInData));
      end else begin
        chk(busOutData == (8'(expAddr) ^ 8'hA5), "R6", "outbound data",
            int'(busOutData), int'(8'(expAddr) ^ 8'hA5));
      end
      @(posedge clk);
      if (!stall) begin
        expAddr = (expAddr + 1) % FULL;
        expCnt  = (expCnt + 1) % FULL;
        left--;
        if (!dirIn && stsPh && left == 2) begin
          expCnt = (expCnt + 1) % FULL;
          left   = 1;
        end
      end
      cyc++;
      @(negedge clk);
    end
    busInValid  = 1'b0;
    busOutReady = 1'b0;
    chk(donePulse == 1'b1, "R8", "done pulse", int'(donePulse), 1);
    chk(dmaEnd && intReq, "R8", "end and interrupt flags", int'(dmaEnd & intReq), 1);
    chk(busy == 1'b0, "R8", "idle after done", int'(busy), 0);
    chk(int'(countQ) == 0, "R4", "count reaches zero", int'(countQ), 0);
    chk(int'(addrQ) == expAddr, "R4", "final address", int'(addrQ), expAddr);
    @(posedge clk);
    @(negedge clk);
    chk(donePulse == 1'b0, "R8", "single done pulse", int'(donePulse), 0);
    chk(dmaEnd && intReq, "R8", "flags sticky", int'(dmaEnd & intReq), 1);
    busStatusPhase = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(addrQ == '0 && countQ == '0 && dirQ == '0, "R3", "reset registers",
        int'(addrQ) + int'(countQ) + int'(dirQ), 0);
    chk(!busy && !dmaEnd && !intReq && !donePulse, "R8", "reset status",
        int'(busy) + int'(dmaEnd) + int'(intReq) + int'(donePulse), 0);

    // R2: byte-pair address sweep over all high values
    for (int hi = 0; hi < 64; hi++) begin
      int lo = (hi * 37 + 11) & 8'hFF;
      writeReg(2'd0, hi | 8'hC0, 1'b1);
      chk(int'(addrQ) == (hi << 8), "R2", "high byte write", int'(addrQ), hi << 8);
      writeReg(2'd0, lo, 1'b1);
      chk(int'(addrQ) == ((hi << 8) | lo), "R2", "low byte OR", int'(addrQ), (hi << 8) | lo);
    end

    // R1: full-width address writes
    writeReg(2'd0, 14'h3FFF, 1'b0);
    chk(int'(addrQ) == 14'h3FFF, "R1", "full address write", int'(addrQ), 14'h3FFF);
    writeReg(2'd0, 14'h1234, 1'b0);
    chk(int'(addrQ) == 14'h1234, "R1", "full address write", int'(addrQ), 14'h1234);

    // R3: count and direction readback
    writeReg(2'd1, 14'h2A5A, 1'b0);
    chk(int'(countQ) == 14'h2A5A, "R3", "count write", int'(countQ), 14'h2A5A);
    writeReg(2'd2, 14'h01FE, 1'b0);
    chk(int'(dirQ) == 8'hFE, "R3", "direction write", int'(dirQ), 8'hFE);

    // R4 R6: length sweep in both directions, assorted out codes
    for (int n = 1; n <= 20; n++) begin
      runBurst(n, 1, n * 100, 1'b0, 0);
      runBurst(n, (n % 2) ? 0 : 8'hFF, n * 300, 1'b0, 0);
    end

    // R10: stalls in both directions
    runBurst(9, 1, 14'h0800, 1'b0, 3);
    runBurst(9, 2, 14'h0900, 1'b0, 2);

    // R4: address wraps at 14 bits
    runBurst(4, 0, 14'h3FFE, 1'b0, 0);

    // R7: status-phase shortening (out), no effect inbound
    for (int n = 2; n <= 6; n++) runBurst(n, 0, 14'h0200, 1'b1, 0);
    runBurst(5, 0, 14'h0300, 1'b1, 2);
    runBurst(5, 1, 14'h0400, 1'b1, 0);

    // R11 R3: start and register write while busy are ignored
    writeReg(2'd0, 14'h0100, 1'b0);
    writeReg(2'd1, 14'h3FFE, 1'b0);
    writeReg(2'd2, 0, 1'b0);
    pulseStart();
    startReq  = 1'b1;
    regWrEn   = 1'b1;
    regSel    = 2'd1;
    regWrData = 14'h0005;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0;
    regWrEn  = 1'b0;
    chk(int'(countQ) == 14'h3FFE, "R3", "write while busy ignored", int'(countQ), 14'h3FFE);
    for (int k = 1; k < DELAY; k++) begin
      chk(!busOutValid, "R11", "latency unchanged", int'(busOutValid), 0);
      @(posedge clk);
      @(negedge clk);
    end
    chk(busOutValid == 1'b1, "R11", "strobe on schedule", int'(busOutValid), 1);
    begin
      int hs = 0;
      int guard = 0;
      busOutReady = 1'b1;
      while (busy && guard < 20) begin
        #1;
        if (busOutValid) hs++;
        @(posedge clk);
        @(negedge clk);
        guard++;
      end
      busOutReady = 1'b0;
      chk(hs == 2, "R11", "bytes moved after ignored start", hs, 2);
      chk(donePulse == 1'b1, "R8", "done after ignored start", int'(donePulse), 1);
    end

    // R5: zero count moves the full buffer
    runBurst(FULL, 1, 14'h0010, 1'b0, 0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule